// File: doc/BRIEF.md
# Square-Wave Frequency Synthesizer with Idle Floor

This block turns a 14-bit frequency word into a square wave. A phase accumulator, 20 bits wide, adds the held word on every reference tick. Each carry out of its top bit produces a one-cycle pulse. The pulse is the raw oscillator output. In the normal mode a toggle flop follows the pulse, so the output runs at half the pulse rate with an even mark-to-space ratio. Software therefore programs the word for twice the frequency it wants at the output.

The toggle flop can also be taken out of the path, and the raw pulse then drives the output. While the toggle flop is in use, an idle guard counts the clock cycles since the output last changed. If the count reaches its limit, the guard forces a toggle. A zero word, or a very small one, then still gives a slow square wave and never a stuck level. The word is loaded with a strobe. The reference tick comes from outside, so a divided clock can pace the accumulator.

Top module: `nco_square_gen`

## Requirements
- R1: A pulse on `load_word` captures `freq_word`, zero-extended to the accumulator width, at that clock edge. A tick in the same cycle as the load still adds the previous word. Every later tick adds the new word. `freq_word` has no effect while `load_word` is low. The word is 0 after reset.
- R2: The accumulator advances only on cycles with `ref_tick` high. Without ticks, no pulse is produced.
- R3: `nco_pulse` is high for exactly one cycle, in the cycle after a tick whose addition carries out of bit 19. With word 8192, a pulse occurs every 128 ticks.
- R4: With `div_en` high, `wave_out` changes state in the cycle after each `nco_pulse`. This gives half the pulse rate with equal high and low times. For word 8192 and a tick every cycle, the output is high for 512 of any 1024 consecutive cycles.
- R5: With `div_en` low, `wave_out` equals `nco_pulse` in every cycle. The toggle flop and the idle guard are then held cleared, so with word 0 the output stays low.
- R6: With `div_en` high, if `WDOG_LIMIT` clock cycles pass without an output change, the guard forces a toggle at the end of the last of them. The guard count restarts on every toggle, whatever its source.
- R7: A pulse that arrives in the same cycle as a guard timeout causes a single toggle, and the guard count restarts from it.
- R8: With word 0 and `div_en` high, `nco_pulse` stays low. `wave_out` toggles every `WDOG_LIMIT` cycles, so its period is twice that.
- R9: `rst` is synchronous and active high. It clears the word, the accumulator, the pulse, the toggle flop and the guard, so both outputs read 0 during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Enables one accumulator step in this cycle |
| load_word | input | 1 | Captures `freq_word` at this edge |
| freq_word | input | 14 | Frequency word |
| div_en | input | 1 | 1: divide-by-two toggle output; 0: raw pulse output |
| nco_pulse | output | 1 | Registered one-cycle carry pulse |
| wave_out | output | 1 | Output waveform |

## Verification
Several properties hold on every cycle and are checked there. A pulse can only follow a tick and is never two cycles long. In divide mode every pulse flips the output on the next edge. In bypass mode the output follows the pulse. The output never stays unchanged for more than the guard limit. The exact cycle in which a new word first takes effect, and the pulse rate for a given word, can only be shown by the bench scenarios. The same holds for the 50% duty count over a window, the single toggle and counter restart when a pulse meets a timeout, and the floor period with a zero word.

// File: rtl/nco_sq_pkg.sv
package nco_sq_pkg;

  typedef enum logic {
    OUT_RAW  = 1'b0,
    OUT_HALF = 1'b1
  } out_mode_e;

  typedef struct packed {
    logic from_nco;
    logic from_guard;
  } toggle_src_t;

  function automatic logic any_src(input toggle_src_t s);
    return s.from_nco | s.from_guard;
  endfunction

endpackage

// File: rtl/nco_phase_accum.sv
module nco_phase_accum #(
  parameter int WORD_W = 14,
  parameter int ACC_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              load,
  input  logic [WORD_W-1:0] word_in,
  output logic              carry_pulse
);
  localparam int PAD_W = ACC_W - WORD_W;

  logic [ACC_W-1:0] step_q;
  logic [ACC_W-1:0] phase_q;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, phase_q} + {1'b0, step_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q      <= '0;
      phase_q     <= '0;
      carry_pulse <= 1'b0;
    end else begin
      if (load) step_q <= {{PAD_W{1'b0}}, word_in};
      if (tick) phase_q <= sum[ACC_W-1:0];
      carry_pulse <= tick & sum[ACC_W];
    end
  end
endmodule

// File: rtl/nco_idle_guard.sv
module nco_idle_guard #(
  parameter int LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic restart,
  output logic fire
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q;

  assign fire = arm && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm || restart) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nco_toggle_stage.sv
module nco_toggle_stage
  import nco_sq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable,
  input  toggle_src_t src,
  output logic        state_q,
  output logic        evt
);
  assign evt = enable & any_src(src);

  always_ff @(posedge clk) begin
    if (rst || !enable) state_q <= 1'b0;
    else                state_q <= state_q ^ evt;
  end
endmodule

// File: rtl/nco_square_gen.sv
module nco_square_gen
  import nco_sq_pkg::*;
#(
  parameter int WORD_W     = 14,
  parameter int ACC_W      = 20,
  parameter int WDOG_LIMIT = 1000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              load_word,
  input  logic [WORD_W-1:0] freq_word,
  input  logic              div_en,
  output logic              nco_pulse,
  output logic              wave_out
);
  out_mode_e   mode;
  toggle_src_t src;
  logic        guard_fire;
  logic        toggle_evt;
  logic        half_q;

  assign mode = out_mode_e'(div_en);

  nco_phase_accum #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .tick(ref_tick), .load(load_word),
    .word_in(freq_word), .carry_pulse(nco_pulse)
  );

  nco_idle_guard #(.LIMIT(WDOG_LIMIT)) u_guard (
    .clk(clk), .rst(rst), .arm(mode == OUT_HALF),
    .restart(toggle_evt), .fire(guard_fire)
  );

  assign src.from_nco   = nco_pulse;
  assign src.from_guard = guard_fire;

  nco_toggle_stage u_tog (
    .clk(clk), .rst(rst), .enable(mode == OUT_HALF),
    .src(src), .state_q(half_q), .evt(toggle_evt)
  );

  assign wave_out = (mode == OUT_HALF) ? half_q : nco_pulse;
endmodule

// File: rtl/nco_square_gen_chk.sv
module nco_square_gen_chk #(
  parameter int WDOG_LIMIT = 1000000
) (
  input logic clk,
  input logic rst,
  input logic ref_tick,
  input logic div_en,
  input logic nco_pulse,
  input logic wave_out
);
  localparam int SC_W = $clog2(WDOG_LIMIT + 3);

  logic            prev_q;
  logic [SC_W-1:0] still_q;

  always_ff @(posedge clk) begin
    prev_q <= wave_out;
    if (rst || !div_en || (wave_out != prev_q)) still_q <= '0;
    else if (still_q != {SC_W{1'b1}})           still_q <= still_q + 1'b1;
  end

  assert_pulse_after_tick_R2: assert property (@(posedge clk) disable iff (rst)
    nco_pulse |-> $past(ref_tick));

  assert_pulse_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    nco_pulse |=> !nco_pulse);

  assert_pulse_flips_R4: assert property (@(posedge clk) disable iff (rst)
    (div_en && nco_pulse) |=> (!div_en || wave_out != $past(wave_out)));

  assert_raw_follow_R5: assert property (@(posedge clk) disable iff (rst)
    !div_en |-> (wave_out == nco_pulse));

  assert_floor_R6: assert property (@(posedge clk) disable iff (rst)
    div_en |-> (int'(still_q) <= WDOG_LIMIT + 1));
endmodule

bind nco_square_gen nco_square_gen_chk #(.WDOG_LIMIT(WDOG_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .div_en(div_en),
  .nco_pulse(nco_pulse), .wave_out(wave_out)
);

// File: tb/nco_square_gen_test.sv
`timescale 1ns/1ps
module nco_square_gen_test;
  localparam int LIM = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_tick = 1'b0;
  logic load_word = 1'b0;
  logic [13:0] freq_word = '0;
  logic div_en = 1'b0;
  logic nco_pulse, wave_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int pulses, highs, diffs;

  always #2.5 clk = ~clk;

  nco_square_gen #(.WORD_W(14), .ACC_W(20), .WDOG_LIMIT(LIM)) uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .load_word(load_word),
    .freq_word(freq_word), .div_en(div_en), .nco_pulse(nco_pulse),
    .wave_out(wave_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic run_count(input int n);
    pulses = 0; highs = 0; diffs = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      pulses += int'(nco_pulse);
      highs  += int'(wave_out);
      diffs  += int'(wave_out != nco_pulse);
    end
  endtask

  task automatic do_reset(input logic mode);
    rst = 1'b1; load_word = 1'b0; ref_tick = 1'b0; freq_word = '0; div_en = mode;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; ref_tick = 1'b1; load_word = 1'b1; freq_word = 14'h3fff; div_en = 1'b1;
    step(4);
    chk("R9 pulse in reset", int'(nco_pulse), 0);
    chk("R9 wave in reset", int'(wave_out), 0);
  endtask

  task automatic t_load_timing;
    do_reset(1'b0);
    ref_tick = 1'b1; load_word = 1'b1; freq_word = 14'd8192;
    step(1);
    load_word = 1'b0; freq_word = 14'd5;
    step(127);
    chk("R1 load-cycle tick used old word", int'(nco_pulse), 0);
    step(1);
    chk("R3 pulse after 128 ticks of new word", int'(nco_pulse), 1);
    step(1);
    chk("R3 pulse one cycle wide", int'(nco_pulse), 0);
    ref_tick = 1'b0;
    run_count(300);
    chk("R2 no pulses without ticks", pulses, 0);
    ref_tick = 1'b1;
    run_count(256);
    chk("R1 unloaded word ignored, rate kept", pulses, 2);
  endtask

  task automatic t_divide;
    do_reset(1'b1);
    ref_tick = 1'b1; load_word = 1'b1; freq_word = 14'd8192;
    step(1);
    load_word = 1'b0;
    step(128);
    chk("R3 first pulse", int'(nco_pulse), 1);
    chk("R4 wave before toggle", int'(wave_out), 0);
    step(1);
    chk("R4 wave toggled after pulse", int'(wave_out), 1);
    run_count(1024);
    chk("R4 high cycles in window", highs, 512);
    chk("R3 pulses in window", pulses, 8);
    rst = 1'b1;
    step(1);
    chk("R9 mid-run reset wave", int'(wave_out), 0);
    chk("R9 mid-run reset pulse", int'(nco_pulse), 0);
  endtask

  task automatic t_bypass;
    do_reset(1'b0);
    ref_tick = 1'b1; load_word = 1'b1; freq_word = 14'd8192;
    step(1);
    load_word = 1'b0;
    run_count(1024);
    chk("R5 raw output mismatches", diffs, 0);
    chk("R5 raw pulses seen", pulses, 8);
    do_reset(1'b0);
    ref_tick = 1'b1;
    run_count(700);
    chk("R5 guard idle in bypass", highs, 0);
  endtask

  task automatic t_idle_floor;
    do_reset(1'b1);
    ref_tick = 1'b1;
    run_count(299);
    chk("R8 zero word no pulse", pulses, 0);
    chk("R6 no early forced toggle", highs, 0);
    step(1);
    chk("R8 forced toggle at limit", int'(wave_out), 1);
    run_count(299);
    chk("R8 held high for limit", highs, 299);
    step(1);
    chk("R8 second forced toggle", int'(wave_out), 0);
  endtask

  task automatic t_coincide;
    do_reset(1'b1);
    load_word = 1'b1; freq_word = 14'd8192;
    step(1);
    load_word = 1'b0;
    step(170);
    ref_tick = 1'b1;
    step(128);
    ref_tick = 1'b0;
    chk("R7 pulse at timeout cycle", int'(nco_pulse), 1);
    chk("R7 wave before joint event", int'(wave_out), 0);
    step(1);
    chk("R7 single toggle on joint event", int'(wave_out), 1);
    step(299);
    chk("R6 restart after joint event", int'(wave_out), 1);
    step(1);
    chk("R6 next forced toggle", int'(wave_out), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_load_timing();
    t_divide();
    t_bypass();
    t_idle_floor();
    t_coincide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule